// File: doc/BRIEF.md
# Control Response Rate Selector

This block picks the transmit rate for a control response (an acknowledgement or a clear-to-send) from the rate of the incoming frame that triggered it. It holds two 16-bit rate bitmaps that the host writes: a basic set and a mandatory set. The search is capped by the incoming frame's rate. The basic set is searched first. If it has nothing at or below the incoming rate, the mandatory set is searched under the same cap.

A rate code is the bit position of that rate inside the bitmaps. The bit order does not follow speed: the four 802.11b rates sit at the low nibble and the eight 802.11g rates at the high byte. So the block ranks candidates by their real bit rate and not by bit index. It answers one clock after each request with a rate code, a found flag and a valid strobe.

Top module: `resp_rate_sel`

## Requirements
- R1: A rate code is the bitmap bit index: 0=1M, 1=2M, 2=5.5M, 3=11M, 8=6M, 9=9M, 10=12M, 11=18M, 12=24M, 13=36M, 14=48M, 15=54M. The 802.11b rates use mask 0x000F and the 802.11g rates use mask 0xFF00.
- R2: For every cycle with `req_valid` high, `rsp_valid` is high for exactly the following cycle. `rsp_valid` is low in every other cycle.
- R3: If the basic set holds any rate whose speed is at or below the incoming rate, the block returns the fastest such rate with `rsp_found` high.
- R4: Candidates are ranked by real speed: 1M < 2M < 5.5M < 6M < 9M < 11M < 12M < 18M < 24M < 36M < 48M < 54M. So 6M beats 5.5M and 11M beats 9M.
- R5: If the basic set has no qualifying rate, the fastest mandatory-set rate at or below the incoming rate is returned with `rsp_found` high.
- R6: If neither set qualifies, `rsp_found` is low. `rsp_code` is then the slowest rate in the mandatory set, or code 0 (1M) if the mandatory set is empty.
- R7: An incoming code of 4, 5, 6 or 7 gives `rsp_found` low, with `rsp_code` chosen as in R6.
- R8: A write with `wr_sel`=0 loads the basic set and a write with `wr_sel`=1 loads the mandatory set. A request made in the same cycle as a write uses the old contents. Requests in later cycles use the new contents.
- R9: After reset, both sets are empty and `rsp_valid`, `rsp_found` and `rsp_code` are 0.
- R10: Bits 4 to 7 of a written bitmap have no effect on any result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bitmap write strobe |
| wr_sel | input | 1 | 0 = basic set, 1 = mandatory set |
| wr_data | input | 16 | Bitmap value to store |
| req_valid | input | 1 | Request strobe |
| req_code | input | 4 | Rate code of the incoming frame |
| rsp_valid | output | 1 | Result strobe, one clock after the request |
| rsp_found | output | 1 | A qualifying rate was found |
| rsp_code | output | 4 | Selected response rate code |

## Verification
A bitmap write and a request can land in the same cycle. The bench provokes this by raising `wr_en` and `req_valid` together with a new bitmap that would change the answer. It judges the response against the pre-write contents, then issues a second request and expects the post-write answer. Apart from that, the bench sweeps all sixteen request codes over many bitmap pairs and compares every response with a speed-based model.

// File: rtl/rrs_pkg.sv
package rrs_pkg;
    localparam int MAP_W   = 16;
    localparam int CODE_W  = 4;
    localparam int N_RATES = 12;
    localparam int RANK_W  = $clog2(N_RATES);

    typedef logic [MAP_W-1:0]   map_t;
    typedef logic [CODE_W-1:0]  code_t;
    typedef logic [RANK_W-1:0]  rank_t;
    typedef logic [N_RATES-1:0] ranked_t;

    typedef struct packed {
        logic  ok;
        rank_t rank;
    } rank_info_t;

    typedef struct packed {
        logic  found;
        code_t code;
    } rsp_t;

    typedef enum logic {SEL_BASIC = 1'b0, SEL_MAND = 1'b1} map_sel_e;

    // codes 4..7 carry no rate
    localparam map_t DEFINED_MASK = 16'hFF0F;

    // speed rank of a code (0 = slowest)
    function automatic rank_info_t rank_of(code_t c);
        rank_info_t r;
        r.ok = 1'b1;
        case (c)
            4'd0:    r.rank = 4'd0;
            4'd1:    r.rank = 4'd1;
            4'd2:    r.rank = 4'd2;
            4'd8:    r.rank = 4'd3;
            4'd9:    r.rank = 4'd4;
            4'd3:    r.rank = 4'd5;
            4'd10:   r.rank = 4'd6;
            4'd11:   r.rank = 4'd7;
            4'd12:   r.rank = 4'd8;
            4'd13:   r.rank = 4'd9;
            4'd14:   r.rank = 4'd10;
            4'd15:   r.rank = 4'd11;
            default: begin r.ok = 1'b0; r.rank = '0; end
        endcase
        return r;
    endfunction

    function automatic code_t code_of(rank_t r);
        code_t c;
        case (r)
            4'd0:    c = 4'd0;
            4'd1:    c = 4'd1;
            4'd2:    c = 4'd2;
            4'd3:    c = 4'd8;
            4'd4:    c = 4'd9;
            4'd5:    c = 4'd3;
            4'd6:    c = 4'd10;
            4'd7:    c = 4'd11;
            4'd8:    c = 4'd12;
            4'd9:    c = 4'd13;
            4'd10:   c = 4'd14;
            default: c = 4'd15;
        endcase
        return c;
    endfunction

    // reorder a bitmap into speed order
    function automatic ranked_t to_ranked(map_t m);
        ranked_t o;
        for (int r = 0; r < N_RATES; r++) begin
            o[r] = m[code_of(rank_t'(r))];
        end
        return o;
    endfunction
endpackage

// File: rtl/rrs_map_regs.sv
module rrs_map_regs
    import rrs_pkg::*;
#(
    parameter map_t BASIC_INIT = '0,
    parameter map_t MAND_INIT  = '0
) (
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  logic wr_sel,
    input  map_t wr_data,
    output map_t basic_q,
    output map_t mand_q
);
    localparam int N_SETS = 2;
    map_t store [N_SETS];

    for (genvar s = 0; s < N_SETS; s++) begin : g_set
        localparam map_t INIT_S = (s == 0) ? BASIC_INIT : MAND_INIT;
        always_ff @(posedge clk) begin
            if (rst) begin
                store[s] <= INIT_S & DEFINED_MASK;
            end else if (wr_en && (wr_sel == 1'(s))) begin
                store[s] <= wr_data & DEFINED_MASK;
            end
        end
    end

    assign basic_q = store[SEL_BASIC];
    assign mand_q  = store[SEL_MAND];
endmodule

// File: rtl/rrs_pick.sv
module rrs_pick
    import rrs_pkg::*;
(
    input  ranked_t cand,
    input  rank_t   limit,
    output logic    hit,
    output rank_t   rank
);
    ranked_t elig;

    for (genvar i = 0; i < N_RATES; i++) begin : g_elig
        assign elig[i] = cand[i] && (RANK_W'(i) <= limit);
    end

    // later index wins: highest qualifying rank
    always_comb begin
        rank = '0;
        for (int i = 0; i < N_RATES; i++) begin
            if (elig[i]) rank = RANK_W'(i);
        end
    end

    assign hit = |elig;
endmodule

// File: rtl/rrs_lowest.sv
module rrs_lowest
    import rrs_pkg::*;
(
    input  ranked_t cand,
    output logic    hit,
    output rank_t   rank
);
    always_comb begin
        rank = '0;
        for (int i = N_RATES - 1; i >= 0; i--) begin
            if (cand[i]) rank = RANK_W'(i);
        end
    end

    assign hit = |cand;
endmodule

// File: rtl/resp_rate_sel.sv
module resp_rate_sel
    import rrs_pkg::*;
#(
    parameter logic [15:0] BASIC_INIT = 16'h0000,
    parameter logic [15:0] MAND_INIT  = 16'h0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic        wr_sel,
    input  logic [15:0] wr_data,
    input  logic        req_valid,
    input  logic [3:0]  req_code,
    output logic        rsp_valid,
    output logic        rsp_found,
    output logic [3:0]  rsp_code
);
    map_t       basic_q, mand_q;
    ranked_t    basic_r, mand_r;
    rank_info_t in_info;
    logic       b_hit, m_hit, low_hit;
    rank_t      b_rank, m_rank, low_rank;
    code_t      fallback;
    rsp_t       nxt, rsp_q;

    rrs_map_regs #(.BASIC_INIT(BASIC_INIT), .MAND_INIT(MAND_INIT)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .basic_q(basic_q), .mand_q(mand_q)
    );

    assign basic_r = to_ranked(basic_q);
    assign mand_r  = to_ranked(mand_q);
    assign in_info = rank_of(req_code);

    rrs_pick u_pick_basic (.cand(basic_r), .limit(in_info.rank), .hit(b_hit), .rank(b_rank));
    rrs_pick u_pick_mand  (.cand(mand_r),  .limit(in_info.rank), .hit(m_hit), .rank(m_rank));
    rrs_lowest u_low      (.cand(mand_r),  .hit(low_hit), .rank(low_rank));

    assign fallback = low_hit ? code_of(low_rank) : code_of('0);

    always_comb begin
        nxt.found = 1'b0;
        nxt.code  = fallback;
        if (in_info.ok) begin
            if (b_hit) begin
                nxt.found = 1'b1;
                nxt.code  = code_of(b_rank);
            end else if (m_hit) begin
                nxt.found = 1'b1;
                nxt.code  = code_of(m_rank);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_q     <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) rsp_q <= nxt;
        end
    end

    assign rsp_found = rsp_q.found;
    assign rsp_code  = rsp_q.code;

    map_t either_q;
    assign either_q = basic_q | mand_q;

    p_rsp_follows_req_r2: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    p_rsp_no_spurious_r2: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);
    p_found_not_above_r3: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (!rsp_found || (rank_of(rsp_code).rank <= rank_of($past(req_code)).rank)));
    p_found_is_member_r5: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (!rsp_found || ((($past(either_q) >> rsp_code) & 16'h0001) == 16'h0001)));
    p_bad_code_r7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !rank_of(req_code).ok) |=> !rsp_found);
    p_code_defined_r1: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> rank_of(rsp_code).ok);
endmodule

// File: tb/test_resp_rate_sel.sv
module test_resp_rate_sel;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [15:0] wr_data = '0;
    logic        req_valid = 1'b0;
    logic [3:0]  req_code = '0;
    logic        rsp_valid, rsp_found;
    logic [3:0]  rsp_code;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #4 clk = ~clk;

    resp_rate_sel i_resp_rate_sel (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .req_valid(req_valid), .req_code(req_code),
        .rsp_valid(rsp_valid), .rsp_found(rsp_found), .rsp_code(rsp_code)
    );

    // speed in units of 100 kb/s; 0 marks an undefined code
    function automatic int speed(int c);
        case (c)
            0: return 10;   1: return 20;   2: return 55;   3: return 110;
            8: return 60;   9: return 90;   10: return 120; 11: return 180;
            12: return 240; 13: return 360; 14: return 480; 15: return 540;
            default: return 0;
        endcase
    endfunction

    task automatic model(input logic [15:0] bm, input logic [15:0] mm, input int code,
                         output bit f, output int ec, output string tag);
        int lim = speed(code);
        int best = 0;
        int lo = 100000;
        f = 0; ec = 0; tag = "R6";
        for (int c = 0; c < 16; c++)
            if (mm[c] && speed(c) != 0 && speed(c) < lo) begin lo = speed(c); ec = c; end
        if (lim == 0) begin tag = "R7"; return; end
        for (int c = 0; c < 16; c++)
            if (bm[c] && speed(c) != 0 && speed(c) <= lim && speed(c) > best) begin
                best = speed(c); ec = c; f = 1; tag = "R3";
            end
        if (f) return;
        for (int c = 0; c < 16; c++)
            if (mm[c] && speed(c) != 0 && speed(c) <= lim && speed(c) > best) begin
                best = speed(c); ec = c; f = 1; tag = "R5";
            end
    endtask

    task automatic check(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic write_map(input bit sel, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic request(input int code);
        @(negedge clk);
        req_valid = 1'b1; req_code = 4'(code);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic req_check(input logic [15:0] bm, input logic [15:0] mm, input int code,
                             input string force_tag);
        bit f; int ec; string tag;
        model(bm, mm, code, f, ec, tag);
        if (force_tag != "") tag = force_tag;
        request(code);
        check("R2", int'(rsp_valid), 1);
        check(tag, {27'b0, rsp_found, rsp_code}, {27'b0, f, 4'(ec)});
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] s = 32'h1234_5678;
        logic [15:0] bm, mm;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R9: reset state
        check("R9", {29'b0, rsp_valid, rsp_found, 1'b0}, 0);
        check("R9", int'(rsp_code), 0);
        req_check(16'h0, 16'h0, 15, "R9");
        @(negedge clk);
        check("R2", int'(rsp_valid), 0);

        // R1: code equals bit index
        write_map(1'b0, 16'h8000); write_map(1'b1, 16'h0000);
        req_check(16'h8000, 16'h0000, 15, "R1");
        write_map(1'b0, 16'h0001);
        req_check(16'h0001, 16'h0000, 0, "R1");

        // R4: ranking by speed
        write_map(1'b0, 16'h0104);
        req_check(16'h0104, 16'h0000, 9, "R4");
        write_map(1'b0, 16'h0208);
        req_check(16'h0208, 16'h0000, 10, "R4");
        req_check(16'h0208, 16'h0000, 9, "R4");

        // R10: reserved bits ignored
        write_map(1'b0, 16'h00F0); write_map(1'b1, 16'h00F0);
        req_check(16'h0000, 16'h0000, 15, "R10");

        // R8: write and request in the same cycle
        write_map(1'b0, 16'h0001); write_map(1'b1, 16'h0000);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 1'b0; wr_data = 16'h8000;
        req_valid = 1'b1; req_code = 4'd15;
        @(negedge clk);
        wr_en = 1'b0; req_valid = 1'b0;
        check("R8", {27'b0, rsp_found, rsp_code}, {27'b0, 1'b1, 4'd0});
        req_check(16'h8000, 16'h0000, 15, "R8");
        write_map(1'b1, 16'h0002);
        req_check(16'h8000, 16'h0002, 14, "R8");

        // sweep bitmap pairs over every code (R3, R5, R6, R7)
        for (int p = 0; p < 40; p++) begin
            s ^= s << 13; s ^= s >> 17; s ^= s << 5;
            bm = s[15:0]; mm = s[31:16];
            if (p % 4 == 1) bm = bm & 16'hFC00;
            if (p % 4 == 2) bm = 16'h0;
            if (p % 8 == 3) mm = 16'h0;
            write_map(1'b0, bm); write_map(1'b1, mm);
            for (int c = 0; c < 16; c++) req_check(bm, mm, c, "");
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule